// File: doc/BRIEF.md
# Watermark-Driven Word Buffer for a Card Host Controller

This block is the data staging store between a system bus and the serial engine of a memory-card host controller. It holds up to 128 words of 32 bits. The system side sees one 32-bit data port: a read strobe takes the oldest word, and a write strobe adds a word. The card side has its own push and pop strobes. A direction input picks which side fills the store and which side drains it. In receive mode the card pushes and the system reads. In transmit mode the system writes and the card pops. Changing the direction empties the store.

Two 7-bit thresholds, one per direction, pace an external DMA engine. In receive mode a request stays high while the number of stored words is above the receive threshold. In transmit mode a request stays high while the number of free slots is above the transmit threshold. Status outputs give the live fill level, full and empty, and two sticky error flags. One flag records a read from an empty store and the other a write into a full one. A write-one-to-clear input clears each flag.

Top module: `wbuf_dma_wm`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, both error flags and both DMA requests are 0, the direction is receive (`dir_tx`=0 is receive, 1 is transmit), and both read-data outputs are 0.
- R2: In receive mode, words pushed by the card are returned on `sys_rdata` in arrival order. The word taken by a `sys_rd` strobe appears on the clock edge that takes it and holds until the next accepted read.
- R3: In transmit mode, words written through `sys_wr` are returned on `card_rdata` in write order. The word taken by a `card_pop` strobe appears on the clock edge that takes it.
- R4: `level` counts the stored words from 0 to 128. `full` is 1 exactly at 128 and `empty` is 1 exactly at 0. Both update on the edge that changes the count.
- R5: `rx_dma_req` is 1 only in receive mode and only while `level` is above the effective receive threshold. It follows `level` and `rd_wm` with no register delay.
- R6: `tx_dma_req` is 1 only in transmit mode and only while 128 minus `level` is above the effective transmit threshold. It follows `level` and `wr_wm` with no register delay.
- R7: A threshold value of 0 acts as 1 in both directions.
- R8: A pop strobe on the active drain side while the store is empty returns 0 on that side's data output, leaves the level at 0 and sets `underflow`.
- R9: A push strobe on the active fill side while the store is full drops the word, leaves the contents unchanged and sets `overflow`.
- R10: `err_clr` bit 0 clears `underflow` and bit 1 clears `overflow`. A flag that is being set in the same cycle stays set.
- R11: On any edge where `dir_tx` differs from the current direction, the direction changes and the store is emptied. Push and pop strobes in that cycle are ignored. The error flags keep their values.
- R12: The strobes of the inactive side have no effect. In receive mode `sys_wr` and `card_pop` are ignored. In transmit mode `card_push` and `sys_rd` are ignored.
- R13: Full and empty are judged on the level at the start of the cycle. A push and a pop in the same cycle at a level between 1 and 127 both take effect and leave the level unchanged. At level 128 the pop succeeds, the push is dropped and `overflow` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_tx | input | 1 | Direction: 0 receive (card fills), 1 transmit (system fills) |
| rd_wm | input | 7 | Receive threshold on stored words |
| wr_wm | input | 7 | Transmit threshold on free slots |
| sys_wr | input | 1 | System data-port write strobe |
| sys_wdata | input | 32 | System data-port write word |
| sys_rd | input | 1 | System data-port read strobe |
| sys_rdata | output | 32 | System data-port read word |
| card_push | input | 1 | Card-side push strobe |
| card_wdata | input | 32 | Card-side word to store |
| card_pop | input | 1 | Card-side pop strobe |
| card_rdata | output | 32 | Card-side word taken |
| err_clr | input | 2 | Write-one-to-clear: bit 0 underflow, bit 1 overflow |
| level | output | 8 | Number of stored words |
| full | output | 1 | Store holds 128 words |
| empty | output | 1 | Store holds no words |
| underflow | output | 1 | Sticky: pop from empty store |
| overflow | output | 1 | Sticky: push into full store |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Every strobe is registered once. The fill level, full and empty, the error flags and the read word all change on the first rising edge after the strobe is driven. The two DMA requests are combinational from the registered level and the threshold inputs. They therefore move on the same edge as the level, and they move within the same cycle when only a threshold changes. The bench drives strobes on falling edges and checks status on the next falling edge. Its monitor compares each taken word 1 ns after the rising edge that takes it, against a queue filled when the strobe was driven. Threshold-only changes are checked 1 ns after the new value is applied.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } err_flags_t;

    // A threshold of zero is promoted to one.
    function automatic int unsigned wm_floor(input int unsigned wm);
        return (wm == 0) ? 1 : wm;
    endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     count,
    output logic              is_full,
    output logic              is_empty,
    output logic              push_drop,
    output logic              pop_miss
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] rd_q;
    logic              do_push, do_pop;

    assign is_full   = (cnt == CW'(DEPTH));
    assign is_empty  = (cnt == '0);
    assign do_push   = push && !is_full;
    assign do_pop    = pop && !is_empty;
    assign push_drop = push && is_full;
    assign pop_miss  = pop && is_empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (!flush && pop) begin
            rd_q <= is_empty ? '0 : mem[rp];
        end
    end

    assign pop_data = rd_q;
    assign count    = cnt;
endmodule

// File: rtl/wbuf_errflags.sv
module wbuf_errflags
    import wbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_unf,
    input  logic       set_ovf,
    input  logic [1:0] clr,
    output err_flags_t flags
);
    err_flags_t f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q.unf <= set_unf || (f_q.unf && !clr[0]);
            f_q.ovf <= set_ovf || (f_q.ovf && !clr[1]);
        end
    end

    assign flags = f_q;
endmodule

// File: rtl/wbuf_dmareq.sv
module wbuf_dmareq
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WM_W  = 7,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] count,
    input  logic [WM_W-1:0] rd_wm,
    input  logic [WM_W-1:0] wr_wm,
    output logic          rx_req,
    output logic          tx_req
);
    logic [CW-1:0] free_slots;
    int unsigned   rx_lim, tx_lim;

    always_comb begin
        free_slots = CW'(DEPTH) - count;
        rx_lim     = wm_floor(32'(rd_wm));
        tx_lim     = wm_floor(32'(wr_wm));
        rx_req     = (mode == MODE_RX) && (32'(count) > rx_lim);
        tx_req     = (mode == MODE_TX) && (32'(free_slots) > tx_lim);
    end
endmodule

// File: rtl/wbuf_dma_wm.sv
module wbuf_dma_wm
    import wbuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    parameter int WM_W   = 7,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_tx,
    input  logic [WM_W-1:0]   rd_wm,
    input  logic [WM_W-1:0]   wr_wm,
    input  logic              sys_wr,
    input  logic [DATA_W-1:0] sys_wdata,
    input  logic              sys_rd,
    output logic [DATA_W-1:0] sys_rdata,
    input  logic              card_push,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_pop,
    output logic [DATA_W-1:0] card_rdata,
    input  logic [1:0]        err_clr,
    output logic [CW-1:0]     level,
    output logic              full,
    output logic              empty,
    output logic              underflow,
    output logic              overflow,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    xfer_mode_e        mode_q;
    logic              switching;
    logic              act_push, act_pop;
    logic [DATA_W-1:0] act_data;
    logic [DATA_W-1:0] taken;
    logic              drop, miss;
    err_flags_t        flags;

    assign switching = (xfer_mode_e'(dir_tx) != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RX;
        else     mode_q <= xfer_mode_e'(dir_tx);
    end

    // Route the fill and drain roles by direction.
    always_comb begin
        if (mode_q == MODE_TX) begin
            act_push = sys_wr;
            act_data = sys_wdata;
            act_pop  = card_pop;
        end else begin
            act_push = card_push;
            act_data = card_wdata;
            act_pop  = sys_rd;
        end
        act_push = act_push && !switching;
        act_pop  = act_pop && !switching;
    end

    wbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (switching),
        .push      (act_push),
        .push_data (act_data),
        .pop       (act_pop),
        .pop_data  (taken),
        .count     (level),
        .is_full   (full),
        .is_empty  (empty),
        .push_drop (drop),
        .pop_miss  (miss)
    );

    wbuf_errflags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_unf (miss),
        .set_ovf (drop),
        .clr     (err_clr),
        .flags   (flags)
    );

    wbuf_dmareq #(.DEPTH(DEPTH), .WM_W(WM_W)) u_req (
        .mode   (mode_q),
        .count  (level),
        .rd_wm  (rd_wm),
        .wr_wm  (wr_wm),
        .rx_req (rx_dma_req),
        .tx_req (tx_dma_req)
    );

    assign sys_rdata  = taken;
    assign card_rdata = taken;
    assign underflow  = flags.unf;
    assign overflow   = flags.ovf;
endmodule

// File: rtl/wbuf_dma_wm_chk.sv
module wbuf_dma_wm_chk #(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          dir_tx,
    input logic          mode_q,
    input logic [CW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          underflow,
    input logic          overflow,
    input logic [1:0]    err_clr,
    input logic          rx_dma_req,
    input logic          tx_dma_req,
    input logic          sys_wr,
    input logic          sys_rd,
    input logic          card_push,
    input logic          card_pop
);
    logic fill_s, drain_s, steady;
    assign fill_s  = mode_q ? sys_wr : card_push;
    assign drain_s = mode_q ? card_pop : sys_rd;
    assign steady  = (dir_tx == mode_q);

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        32'(level) <= DEPTH);

    assert_full_vs_empty_R4: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_level_step_R13: assert property (@(posedge clk) disable iff (rst)
        steady |=> ((int'(level) - int'($past(level)) <= 1) &&
                    (int'($past(level)) - int'(level) <= 1)));

    assert_single_req_R5: assert property (@(posedge clk) disable iff (rst)
        !(rx_dma_req && tx_dma_req));

    assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (underflow && !err_clr[0]) |=> underflow);

    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
        (steady && empty && drain_s) |=> underflow);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overflow && !err_clr[1]) |=> overflow);

    assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (steady && full && fill_s && !drain_s) |=> (full && overflow));

    assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (err_clr[1] && !(steady && full && fill_s)) |=> !overflow);

    assert_flush_R11: assert property (@(posedge clk) disable iff (rst)
        !steady |=> (empty && level == '0));
endmodule

bind wbuf_dma_wm wbuf_dma_wm_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir_tx     (dir_tx),
    .mode_q     (mode_q),
    .level      (level),
    .full       (full),
    .empty      (empty),
    .underflow  (underflow),
    .overflow   (overflow),
    .err_clr    (err_clr),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req),
    .sys_wr     (sys_wr),
    .sys_rd     (sys_rd),
    .card_push  (card_push),
    .card_pop   (card_pop)
);

// File: tb/sim_wbuf_dma_wm.sv
module sim_wbuf_dma_wm;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        dir_tx;
    logic [6:0]  rd_wm, wr_wm;
    logic        sys_wr, sys_rd, card_push, card_pop;
    logic [31:0] sys_wdata, card_wdata, sys_rdata, card_rdata;
    logic [1:0]  err_clr;
    logic [7:0]  level;
    logic        full, empty, underflow, overflow, rx_dma_req, tx_dma_req;

    always #5 clk = ~clk;

    wbuf_dma_wm u0 (
        .clk(clk), .rst(rst), .dir_tx(dir_tx), .rd_wm(rd_wm), .wr_wm(wr_wm),
        .sys_wr(sys_wr), .sys_wdata(sys_wdata), .sys_rd(sys_rd), .sys_rdata(sys_rdata),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
        .card_rdata(card_rdata), .err_clr(err_clr), .level(level), .full(full),
        .empty(empty), .underflow(underflow), .overflow(overflow),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    // Reference model built from the requirements.
    logic [31:0] model[$];
    bit          m_tx, m_unf, m_ovf;
    logic [31:0] exp_d[$];
    string       exp_tag[$];
    bit          mon_pop, mon_tx;
    logic [31:0] mon_e;
    string       mon_t;
    int          n_checks = 0, n_fail = 0;
    bit          done = 0;
    logic [31:0] next_word = 32'hA500_0000;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare each taken word just after the edge that takes it.
    always @(posedge clk) begin
        if (mon_pop) begin
            #1;
            if (exp_d.size() == 0) begin
                chk("R2", "unexpected pop", 32'd1, 32'd0);
            end else begin
                mon_e = exp_d.pop_front();
                mon_t = exp_tag.pop_front();
                chk(mon_t, "taken word", mon_tx ? card_rdata : sys_rdata, mon_e);
            end
        end
    end

    // Driver: one cycle of strobes, starting and ending at a falling edge.
    task automatic step(input bit c_push, input bit c_pop, input bit s_wr,
                        input bit s_rd, input logic [1:0] clr);
        bit a_push, a_pop, had, room;
        logic [31:0] a_dat;
        card_push  = c_push; card_pop = c_pop; sys_wr = s_wr; sys_rd = s_rd;
        card_wdata = next_word; sys_wdata = next_word; err_clr = clr;
        a_push = m_tx ? s_wr : c_push;
        a_pop  = m_tx ? c_pop : s_rd;
        a_dat  = next_word;
        if (a_push) next_word = next_word + 32'h0001_0003;
        had  = model.size() > 0;
        room = model.size() < DEPTH;
        if (a_pop) begin
            exp_d.push_back(had ? model[0] : 32'd0);
            exp_tag.push_back(had ? (m_tx ? "R3" : "R2") : "R8");
        end
        m_unf = (a_pop && !had) || (m_unf && !clr[0]);
        m_ovf = (a_push && !room) || (m_ovf && !clr[1]);
        if (a_pop && had) void'(model.pop_front());
        if (a_push && room) model.push_back(a_dat);
        mon_pop = a_pop; mon_tx = m_tx;
        @(negedge clk);
        card_push = 0; card_pop = 0; sys_wr = 0; sys_rd = 0; err_clr = 2'b00;
        mon_pop = 0;
    endtask

    task automatic fill_one();  step(!m_tx, 0, m_tx, 0, 2'b00); endtask
    task automatic drain_one(); step(0, m_tx, 0, !m_tx, 2'b00); endtask
    task automatic fill_n(input int n);  for (int i = 0; i < n; i++) fill_one();  endtask
    task automatic drain_n(input int n); for (int i = 0; i < n; i++) drain_one(); endtask

    task automatic switch_dir(input bit tx);
        dir_tx = tx; card_push = 1; sys_wr = 1; sys_rd = 1; card_pop = 1;
        @(negedge clk);
        card_push = 0; sys_wr = 0; sys_rd = 0; card_pop = 0;
        model.delete(); m_tx = tx;
    endtask

    task automatic chk_status(input string req);
        chk(req, "level", 32'(level), model.size());
        chk(req, "full",  32'(full),  32'(model.size() == DEPTH));
        chk(req, "empty", 32'(empty), 32'(model.size() == 0));
    endtask

    task automatic chk_flags(input string req);
        chk(req, "underflow", 32'(underflow), 32'(m_unf));
        chk(req, "overflow",  32'(overflow),  32'(m_ovf));
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst = 1; dir_tx = 0; rd_wm = 7'd4; wr_wm = 7'd100;
        sys_wr = 0; sys_rd = 0; card_push = 0; card_pop = 0;
        sys_wdata = 0; card_wdata = 0; err_clr = 0;
        m_tx = 0; m_unf = 0; m_ovf = 0; mon_pop = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk_status("R1"); chk_flags("R1");
        chk("R1", "rx req", 32'(rx_dma_req), 0);
        chk("R1", "tx req", 32'(tx_dma_req), 0);
        chk("R1", "sys_rdata", sys_rdata, 0);

        // Receive: five words in, threshold 4
        fill_n(5);
        chk_status("R4");
        chk("R5", "rx req at 5>4", 32'(rx_dma_req), 1);
        chk("R5", "tx req in rx mode", 32'(tx_dma_req), 0);
        drain_one();
        chk("R5", "rx req drops at 4", 32'(rx_dma_req), 0);
        rd_wm = 7'd0; #1;
        chk("R7", "rx req, wm 0 at level 4", 32'(rx_dma_req), 1);
        drain_n(2);
        chk("R7", "rx req, wm 0 at level 2", 32'(rx_dma_req), 1);
        drain_one();
        chk("R7", "rx req, wm 0 at level 1", 32'(rx_dma_req), 0);

        // R12 inactive strobes in receive mode
        step(0, 1, 1, 0, 2'b00);
        chk_status("R12");
        chk("R12", "rx level unchanged", 32'(level), 1);

        // R8 empty read
        drain_one();
        drain_one();
        chk_status("R8"); chk_flags("R8");
        chk("R8", "underflow set", 32'(underflow), 1);
        step(0, 0, 0, 0, 2'b01);
        chk("R10", "underflow cleared", 32'(underflow), 0);
        step(0, 0, 0, 1, 2'b01);
        chk("R10", "set wins over clear", 32'(underflow), 1);
        step(0, 0, 0, 0, 2'b01);
        chk_flags("R10");

        // R13 simultaneous push and pop mid-level
        fill_n(3);
        step(1, 0, 0, 1, 2'b00);
        chk_status("R13");
        chk("R13", "level held at 3", 32'(level), 3);

        // Fill to the top
        fill_n(DEPTH - 3);
        chk_status("R4");
        chk("R4", "full at 128", 32'(full), 1);
        rd_wm = 7'd127; #1;
        chk("R5", "rx req 128>127", 32'(rx_dma_req), 1);
        fill_one();
        chk_status("R9"); chk_flags("R9");
        chk("R9", "overflow set", 32'(overflow), 1);
        step(0, 0, 0, 0, 2'b10);
        chk("R10", "overflow cleared", 32'(overflow), 0);
        step(1, 0, 0, 1, 2'b00);
        chk_status("R13"); chk_flags("R13");
        chk("R13", "pop at full, push dropped", 32'(level), 127);
        step(0, 0, 0, 0, 2'b10);
        drain_n(127);
        chk_status("R2");

        // R11 direction change flushes but keeps flags
        drain_one();
        fill_n(3);
        switch_dir(1);
        chk_status("R11"); chk_flags("R11");
        chk("R11", "level after switch", 32'(level), 0);
        chk("R11", "underflow kept", 32'(underflow), 1);
        step(0, 0, 0, 0, 2'b01);

        // Transmit thresholds
        chk("R6", "tx req free 128>100", 32'(tx_dma_req), 1);
        chk("R5", "rx req in tx mode", 32'(rx_dma_req), 0);
        fill_n(27);
        chk("R6", "tx req free 101>100", 32'(tx_dma_req), 1);
        fill_one();
        chk("R6", "tx req free 100", 32'(tx_dma_req), 0);
        wr_wm = 7'd0; #1;
        chk("R7", "tx req, wm 0", 32'(tx_dma_req), 1);
        wr_wm = 7'd127; #1;
        chk("R6", "tx req free 100<=127", 32'(tx_dma_req), 0);

        // R12 inactive strobes in transmit mode
        step(1, 0, 0, 1, 2'b00);
        chk_status("R12");
        chk("R12", "tx level unchanged", 32'(level), 28);

        // R3 order, then overflow and full drain in transmit
        drain_n(5);
        fill_n(DEPTH - 23);
        chk_status("R4");
        fill_one();
        chk_flags("R9");
        chk("R9", "tx overflow", 32'(overflow), 1);
        drain_n(DEPTH);
        chk_status("R3");
        drain_one();
        chk_flags("R8");
        chk("R8", "tx underflow", 32'(underflow), 1);

        @(negedge clk);
        finish_run();
    end
endmodule